// File: doc/BRIEF.md
# Audio ADC Serial Data Transmitter

This block sends converted audio samples out on one serial data line, one frame for each period of the frame (left/right) clock. Each frame is made of a left half and a right half. The line carries one bit per bit-clock period, most significant bit first. Configuration inputs select the word length, the bit-clock polarity, the data format and the power-down state. The block does not generate the bit clock or the frame clock. In slave mode it takes both clocks from external pins. In master mode it takes them from a companion clock generator.

Both serial clocks are oversampled in the block's own system clock domain, so all state sits on one clock. Each sample is held in a 32-bit container, aligned to the most significant bit. A sample pair written with the valid strobe waits in a pending register. It moves into the active register only when a new frame begins, so the pair that is transmitted never changes partway through a frame.

Top module: `adc_serial_tx`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `sdata` and `cfg_err` are both 0.
- R2: When `cfg_bclk_inv` is 0, the block reads the frame clock on rising bit-clock edges and changes `sdata` only on falling bit-clock edges. Each bit is valid at the next rising edge.
- R3: When `cfg_bclk_inv` is 1, the edge roles swap. The block reads the frame clock on falling edges, changes `sdata` on rising edges, and each bit is valid at the next falling edge.
- R4: `cfg_wlen` sets the word length: 00 is 16 bits, 01 is 20 bits, 10 is 24 bits and 11 is 32 bits. A word of W bits is sent MSB first, from container bit 31 down to bit 32-W.
- R5: When `cfg_fmt` is 00 (left-justified) or 11 (treated the same way), the MSB is valid in slot 0 of each half. Slot 0 is the first read edge after a frame-clock change. A frame-clock level of 0 selects the left half.
- R6: When `cfg_fmt` is 01 (I2S), the MSB is valid in slot 1 of each half, and a frame-clock level of 1 selects the left half.
- R7: When `cfg_fmt` is 10 (right-justified), the LSB is valid in the last slot of each half. The half length is measured in bit periods from the preceding half. A frame-clock level of 0 selects the left half.
- R8: Every slot of a half that carries no bit of the word is sent as 0.
- R9: When `cfg_fmt` is 10 and `cfg_wlen` is 11 at the same time, `cfg_err` is 1 from the next clock and `sdata` is held at 0 for as long as that combination lasts.
- R10: While `chip_pd` or `adc_pd` is 1, `sdata` is 0 from the next clock onward.
- R11: When `cfg_master` is 1, the block uses `gen_bclk` and `gen_lrclk` and ignores the external pins. When `cfg_master` is 0, it uses `ext_bclk` and `ext_lrclk` and ignores the generator.
- R12: A pair presented with `smp_valid` is transmitted from the next frame start onward, where a frame start is entry into the left half. A pair written partway through a frame does not change the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1 selects the generator clocks (master), 0 selects the external pins (slave) |
| ext_bclk | input | 1 | Bit clock from the external pin |
| ext_lrclk | input | 1 | Frame clock from the external pin |
| gen_bclk | input | 1 | Bit clock from the companion generator |
| gen_lrclk | input | 1 | Frame clock from the companion generator |
| cfg_bclk_inv | input | 1 | Bit-clock polarity select |
| cfg_wlen | input | 2 | Word length code |
| cfg_fmt | input | 2 | Data format code |
| chip_pd | input | 1 | Chip-wide power-down; mutes the output |
| adc_pd | input | 1 | Converter power-down; mutes the output |
| smp_left | input | 32 | Left sample, MSB-aligned |
| smp_right | input | 32 | Right sample, MSB-aligned |
| smp_valid | input | 1 | Strobe that captures the sample pair |
| sdata | output | 1 | Serial data output |
| cfg_err | output | 1 | Flags the forbidden right-justified 32-bit setting |

## Verification
A wrong slot count or a wrong half-length measurement moves every following bit. That error appears at the next read edge, and it is worst in the right-justified format, where the whole word moves. A channel flag holding the wrong value swaps the left and right words for a whole half. Latching the pending pair at the wrong moment shows up as a mixed pair in the frame that was in progress when the strobe arrived. The bench reads the line at every read edge of every slot, across every format, word length and polarity, so any of these faults fails within one half-frame.

// File: rtl/adc_tx_pkg.sv
// Shared types and decode helpers for the serial audio transmitter.
// Assumes samples arrive in a 32-bit container aligned to the MSB.
package adc_tx_pkg;

    // Data format codes on the configuration input
    typedef enum logic [1:0] {
        FMT_LJ     = 2'b00,
        FMT_I2S    = 2'b01,
        FMT_RJ     = 2'b10,
        FMT_LJ_ALT = 2'b11
    } fmt_e;

    // Code for the 32-bit word length, which right-justified format forbids
    localparam logic [1:0] WLEN_CODE_32 = 2'b11;

    // Number of bits in the word for a given word-length code
    function automatic logic [5:0] wlen_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 6'd16;
            2'b01:   return 6'd20;
            2'b10:   return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/adc_tx_edges.sv
// Selects the bit clock and frame clock source, brings both into the
// system clock domain, and turns bit-clock transitions into single-cycle
// launch and sample events. Assumes each bit-clock phase lasts at least
// SYNC_STAGES+2 system clocks. Both clocks pass through equal-length
// pipelines, so the frame clock stays aligned with the bit clock.
module adc_tx_edges #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_gen,
    input  logic ext_bclk,
    input  logic ext_lrclk,
    input  logic gen_bclk,
    input  logic gen_lrclk,
    input  logic bclk_inv,
    output logic launch_ev,
    output logic sample_ev,
    output logic lr_lvl
);

    localparam int TOP = SYNC_STAGES - 1;

    logic           bclk_sel;
    logic           lrclk_sel;
    logic [TOP:0]   b_pipe;
    logic [TOP:0]   l_pipe;
    logic           b_last;
    logic           b_rise;
    logic           b_fall;

    // Source select: generator clocks in master mode, pins in slave mode
    assign bclk_sel  = use_gen ? gen_bclk  : ext_bclk;
    assign lrclk_sel = use_gen ? gen_lrclk : ext_lrclk;

    // Synchronizer chains plus the previous bit-clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_pipe <= '0;
            l_pipe <= '0;
            b_last <= 1'b0;
        end else begin
            b_pipe <= {b_pipe[TOP-1:0], bclk_sel};
            l_pipe <= {l_pipe[TOP-1:0], lrclk_sel};
            b_last <= b_pipe[TOP];
        end
    end

    // Edge classification and role assignment according to polarity
    always_comb begin
        b_rise    = b_pipe[TOP] & ~b_last;
        b_fall    = ~b_pipe[TOP] & b_last;
        sample_ev = bclk_inv ? b_fall : b_rise;
        launch_ev = bclk_inv ? b_rise : b_fall;
        lr_lvl    = l_pipe[TOP];
    end

endmodule

// File: rtl/adc_tx_framer.sv
// Tracks the position in the frame. It reads the frame clock on sample
// events. On each launch event it predicts the slot that the following
// sample edge will see, measures the length of each half, decides the
// channel, and swaps the pending sample pair into the active pair at each
// frame start. The next-state values are exported so that the output stage
// can launch the bit for that slot. Assumes the frame clock changes together
// with a launch edge.
module adc_tx_framer
    import adc_tx_pkg::*;
#(
    parameter int SAMPLE_W = 32,
    parameter int CNT_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch_ev,
    input  logic                sample_ev,
    input  logic                lr_lvl,
    input  fmt_e                fmt,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                smp_valid,
    output logic [CNT_W-1:0]    slot_nxt,
    output logic [CNT_W-1:0]    half_nxt,
    output logic [SAMPLE_W-1:0] word_nxt
);

    localparam logic [CNT_W-1:0] SLOT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic                lr_smp;
    logic                chan_left_q;
    logic [CNT_W-1:0]    slot_q;
    logic [CNT_W-1:0]    half_q;
    logic [CNT_W-1:0]    slot_inc;
    logic [SAMPLE_W-1:0] pend_l, pend_r;
    logic [SAMPLE_W-1:0] act_l, act_r;
    logic                left_lvl;
    logic                boundary;
    logic                frame_start;
    logic                left_nxt;

    // Boundary prediction, channel choice and next slot/half/word values
    always_comb begin
        left_lvl    = (fmt == FMT_I2S);
        boundary    = launch_ev && (lr_lvl != lr_smp);
        frame_start = boundary && (lr_lvl == left_lvl);
        left_nxt    = boundary ? (lr_lvl == left_lvl) : chan_left_q;
        slot_inc    = (slot_q == SLOT_MAX) ? slot_q : slot_q + ONE;
        slot_nxt    = boundary ? '0 : slot_inc;
        half_nxt    = boundary ? slot_inc : half_q;
        if (frame_start)
            word_nxt = pend_l;
        else
            word_nxt = left_nxt ? act_l : act_r;
    end

    // Frame-clock level as seen at the last sample edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            lr_smp <= 1'b0;
        else if (sample_ev)
            lr_smp <= lr_lvl;
    end

    // Slot counter, half-length measurement and channel flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q      <= '0;
            half_q      <= '0;
            chan_left_q <= 1'b0;
        end else if (launch_ev) begin
            slot_q      <= slot_nxt;
            half_q      <= half_nxt;
            chan_left_q <= left_nxt;
        end
    end

    // Pending capture on the strobe; active swap only at a frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_l <= '0;
            pend_r <= '0;
            act_l  <= '0;
            act_r  <= '0;
        end else begin
            if (smp_valid) begin
                pend_l <= smp_left;
                pend_r <= smp_right;
            end
            if (frame_start) begin
                act_l <= pend_l;
                act_r <= pend_r;
            end
        end
    end

    // R12: the active pair changes only at a frame start
    a_r12_active_held: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(act_l) && $stable(act_r)));

    // R7: within a half the slot counter advances by one per launch
    a_r7_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_ev && (lr_lvl == lr_smp) && (slot_q != SLOT_MAX))
        |=> (slot_q == $past(slot_q) + ONE));

endmodule

// File: rtl/adc_tx_shift.sv
// Chooses the bit for the coming slot from the word, the format, the word
// length and the measured half length, and drives the serial line. The line
// updates only on launch events and is forced low while muted. Assumes the
// slot, half length and word inputs are valid whenever launch_ev is high.
module adc_tx_shift
    import adc_tx_pkg::*;
#(
    parameter int SAMPLE_W = 32,
    parameter int CNT_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch_ev,
    input  logic                mute,
    input  fmt_e                fmt,
    input  logic [1:0]          wlen,
    input  logic [CNT_W-1:0]    slot,
    input  logic [CNT_W-1:0]    half_len,
    input  logic [SAMPLE_W-1:0] word,
    output logic                sdata
);

    localparam int IDX_W = $clog2(SAMPLE_W);

    int               w_bits;
    int               offset;
    int               k;
    logic [IDX_W-1:0] idx;
    logic             bit_nxt;

    // Position of the slot within the word for the selected format
    always_comb begin
        w_bits = int'(wlen_bits(wlen));
        case (fmt)
            FMT_I2S: offset = 1;
            FMT_RJ:  offset = int'(half_len) - w_bits;
            default: offset = 0;
        endcase
        k       = int'(slot) - offset;
        idx     = IDX_W'(SAMPLE_W - 1 - k);
        bit_nxt = (k >= 0 && k < w_bits) ? word[idx] : 1'b0;
    end

    // Output register: cleared by mute, loaded on a launch event
    always_ff @(posedge clk) begin
        if (!rst_n)
            sdata <= 1'b0;
        else if (mute)
            sdata <= 1'b0;
        else if (launch_ev)
            sdata <= bit_nxt;
    end

    // R8: in left-justified format, slots beyond the word are sent as zero
    a_r8_lj_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_ev && (fmt == FMT_LJ) && (int'(slot) >= int'(wlen_bits(wlen))))
        |=> !sdata);

endmodule

// File: rtl/adc_serial_tx.sv
// Top of the serial audio transmitter. It connects the clock select and
// edge detector, the frame tracker and the output stage, and it flags the
// forbidden right-justified 32-bit setting. Assumes the configuration
// changes only between frames or under reset.
module adc_serial_tx
    import adc_tx_pkg::*;
#(
    parameter int SAMPLE_W    = 32,
    parameter int CNT_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_master,
    input  logic                ext_bclk,
    input  logic                ext_lrclk,
    input  logic                gen_bclk,
    input  logic                gen_lrclk,
    input  logic                cfg_bclk_inv,
    input  logic [1:0]          cfg_wlen,
    input  logic [1:0]          cfg_fmt,
    input  logic                chip_pd,
    input  logic                adc_pd,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                smp_valid,
    output logic                sdata,
    output logic                cfg_err
);

    fmt_e                fmt_sel;
    logic                launch_ev;
    logic                sample_ev;
    logic                lr_lvl;
    logic [CNT_W-1:0]    slot_nxt;
    logic [CNT_W-1:0]    half_nxt;
    logic [SAMPLE_W-1:0] word_nxt;
    logic                err_cond;
    logic                mute;

    // Format decode, the forbidden-combination check and the mute condition
    always_comb begin
        fmt_sel  = fmt_e'(cfg_fmt);
        err_cond = (fmt_sel == FMT_RJ) && (cfg_wlen == WLEN_CODE_32);
        mute     = chip_pd | adc_pd | err_cond;
    end

    // Registered configuration-error flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_err <= 1'b0;
        else
            cfg_err <= err_cond;
    end

    adc_tx_edges #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .use_gen   (cfg_master),
        .ext_bclk  (ext_bclk),
        .ext_lrclk (ext_lrclk),
        .gen_bclk  (gen_bclk),
        .gen_lrclk (gen_lrclk),
        .bclk_inv  (cfg_bclk_inv),
        .launch_ev (launch_ev),
        .sample_ev (sample_ev),
        .lr_lvl    (lr_lvl)
    );

    adc_tx_framer #(
        .SAMPLE_W(SAMPLE_W),
        .CNT_W   (CNT_W)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_ev (launch_ev),
        .sample_ev (sample_ev),
        .lr_lvl    (lr_lvl),
        .fmt       (fmt_sel),
        .smp_left  (smp_left),
        .smp_right (smp_right),
        .smp_valid (smp_valid),
        .slot_nxt  (slot_nxt),
        .half_nxt  (half_nxt),
        .word_nxt  (word_nxt)
    );

    adc_tx_shift #(
        .SAMPLE_W(SAMPLE_W),
        .CNT_W   (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_ev (launch_ev),
        .mute      (mute),
        .fmt       (fmt_sel),
        .wlen      (cfg_wlen),
        .slot      (slot_nxt),
        .half_len  (half_nxt),
        .word      (word_nxt),
        .sdata     (sdata)
    );

    // R9: the forbidden combination raises the flag on the next clock
    a_r9_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        err_cond |=> cfg_err);

    // R9: while the flag is raised the line stays low
    a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !sdata);

    // R10: power-down mutes the line from the next clock
    a_r10_mute: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_pd || adc_pd) |=> !sdata);

    // R2: without a launch event or a mute the line holds its value
    a_r2_launch_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch_ev && !mute) |=> $stable(sdata));

endmodule

// File: tb/adc_serial_tx_bench.sv
// Self-checking bench. It sweeps every format, word length and polarity at
// two half-frame lengths, then runs the mute, error and clock-source cases.
// It plays the receiver: it reads the line just before each read edge and
// compares it with a bit computed from the requirements.
module adc_serial_tx_bench;

    localparam int HALF = 4;       // system clocks per bit-clock phase
    localparam int WD   = 190000;  // watchdog limit in clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b0;
    logic        ext_bclk = 1'b0, ext_lrclk = 1'b0;
    logic        gen_bclk = 1'b0, gen_lrclk = 1'b0;
    logic        cfg_bclk_inv = 1'b0;
    logic [1:0]  cfg_wlen = 2'b10;
    logic [1:0]  cfg_fmt = 2'b00;
    logic        chip_pd = 1'b0, adc_pd = 1'b0;
    logic [31:0] smp_left = '0, smp_right = '0;
    logic        smp_valid = 1'b0;
    logic        sdata;
    logic        cfg_err;

    int n_chk = 0;
    int n_fail = 0;
    bit use_gen = 1'b0;
    bit expect_zero = 1'b0;

    always #10 clk = ~clk;

    adc_serial_tx u_adc_serial_tx (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
        .ext_bclk(ext_bclk), .ext_lrclk(ext_lrclk),
        .gen_bclk(gen_bclk), .gen_lrclk(gen_lrclk),
        .cfg_bclk_inv(cfg_bclk_inv), .cfg_wlen(cfg_wlen), .cfg_fmt(cfg_fmt),
        .chip_pd(chip_pd), .adc_pd(adc_pd),
        .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid),
        .sdata(sdata), .cfg_err(cfg_err)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int word_bits();
        return (cfg_wlen == 2'b11) ? 32 : 16 + 4 * int'(cfg_wlen);
    endfunction

    // Position of slot s inside the word (R5, R6, R7); out of range means fill
    function automatic int word_pos(input int s, input int h);
        case (cfg_fmt)
            2'b01:   return s - 1;
            2'b10:   return s - (h - word_bits());
            default: return s;
        endcase
    endfunction

    function automatic bit is_muted();
        return expect_zero || chip_pd || adc_pd ||
               (cfg_fmt == 2'b10 && cfg_wlen == 2'b11);
    endfunction

    function automatic logic exp_bit(input logic [31:0] w, input int s, input int h);
        int k;
        k = word_pos(s, h);
        if (is_muted()) return 1'b0;
        if (k < 0 || k >= word_bits()) return 1'b0;
        return w[31 - k];
    endfunction

    function automatic string tag_for(input int s, input int h);
        string f, p;
        int k;
        k = word_pos(s, h);
        if (expect_zero)                              f = "R11";
        else if (chip_pd || adc_pd)                   f = "R10";
        else if (cfg_fmt == 2'b10 && cfg_wlen == 2'b11) f = "R9";
        else if (k < 0 || k >= word_bits())           f = "R8";
        else if (cfg_fmt == 2'b01)                    f = "R6";
        else if (cfg_fmt == 2'b10)                    f = "R7";
        else                                          f = "R5";
        p = cfg_bclk_inv ? "R3" : "R2";
        return $sformatf("%s %s R4 fmt=%0d wlen=%0d slot=%0d", f, p, cfg_fmt, cfg_wlen, s);
    endfunction

    task automatic drive(input logic b, input logic l);
        if (use_gen) begin gen_bclk = b; gen_lrclk = l; end
        else begin ext_bclk = b; ext_lrclk = l; end
    endtask

    // One half-frame: launch level, read just before the read edge, read level
    task automatic run_half(input logic lr, input logic [31:0] w, input int h, input bit chk);
        logic e;
        for (int s = 0; s < h; s++) begin
            drive(cfg_bclk_inv, lr);
            tick(HALF);
            if (chk) begin
                e = exp_bit(w, s, h);
                check(sdata === e, tag_for(s, h), {31'b0, sdata}, {31'b0, e});
            end
            drive(~cfg_bclk_inv, lr);
            tick(HALF);
        end
    endtask

    task automatic pulse_valid(input logic [31:0] l, input logic [31:0] r);
        smp_left = l; smp_right = r; smp_valid = 1'b1;
        tick(1);
        smp_valid = 1'b0;
    endtask

    task automatic do_reset();
        logic right_lvl;
        right_lvl = (cfg_fmt == 2'b01) ? 1'b0 : 1'b1;
        rst_n = 1'b0;
        ext_bclk = ~cfg_bclk_inv; ext_lrclk = right_lvl;
        gen_bclk = ~cfg_bclk_inv; gen_lrclk = right_lvl;
        tick(4);
        rst_n = 1'b1;
        tick(1);
    endtask

    // Reset, warm-up frame, then two checked frames with a new pair mid-way
    task automatic run_cfg(input logic [1:0] f, input logic [1:0] w, input logic inv,
                           input int h, input int seed, input bit r1);
        logic [31:0] al, ar, bl, br;
        logic lft;
        cfg_fmt = f; cfg_wlen = w; cfg_bclk_inv = inv;
        do_reset();
        if (r1) begin
            check(sdata === 1'b0, "R1 sdata after reset", {31'b0, sdata}, 32'h0);
            check(cfg_err === 1'b0, "R1 cfg_err after reset", {31'b0, cfg_err}, 32'h0);
        end
        al = 32'h9E3779B9 * (seed + 1) ^ 32'h5A5A0F0F;
        ar = 32'h85EBCA6B * (seed + 3) ^ 32'h0FF0A55A;
        bl = ~al ^ 32'h1234_5678;
        br = ar ^ 32'hC3C3_3C3C;
        lft = (f == 2'b01);
        pulse_valid(al, ar);
        run_half(lft, al, h, 1'b0);
        run_half(~lft, ar, h, 1'b0);
        // frame 1 keeps the first pair although a new one arrives mid-way (R12)
        run_half(lft, al, h, 1'b1);
        pulse_valid(bl, br);
        run_half(~lft, ar, h, 1'b1);
        // frame 2 carries the new pair (R12)
        run_half(lft, bl, h, 1'b1);
        run_half(~lft, br, h, 1'b1);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d clocks", WD, WD);
        summary();
        $finish;
    end

    initial begin
        int seed;
        seed = 0;
        // R2 R3 R4 R5 R6 R7 R8 R12: full sweep in slave mode
        for (int hs = 0; hs < 2; hs++) begin
            for (int f = 0; f < 3; f++) begin
                for (int w = 0; w < 4; w++) begin
                    for (int inv = 0; inv < 2; inv++) begin
                        if (!(f == 2 && w == 3)) begin
                            run_cfg(2'(f), 2'(w), 1'(inv), (hs == 0) ? 34 : 48, seed, 1'b1);
                            seed++;
                        end
                    end
                end
            end
        end
        // R5: format code 11 behaves as left-justified
        run_cfg(2'b11, 2'b01, 1'b0, 34, seed, 1'b1);

        // R9: forbidden right-justified 32-bit setting
        run_cfg(2'b10, 2'b11, 1'b0, 34, seed + 1, 1'b0);
        check(cfg_err === 1'b1, "R9 cfg_err raised", {31'b0, cfg_err}, 32'h1);
        cfg_wlen = 2'b10;
        tick(2);
        check(cfg_err === 1'b0, "R9 cfg_err cleared", {31'b0, cfg_err}, 32'h0);

        // R10: each power-down input mutes the line, and release restores data
        adc_pd = 1'b1;
        run_cfg(2'b00, 2'b10, 1'b0, 34, seed + 2, 1'b1);
        adc_pd = 1'b0;
        chip_pd = 1'b1;
        run_cfg(2'b01, 2'b00, 1'b1, 34, seed + 3, 1'b1);
        chip_pd = 1'b0;
        run_cfg(2'b10, 2'b01, 1'b0, 34, seed + 4, 1'b1);

        // R11: master mode runs from the generator, with the pins held idle
        use_gen = 1'b1;
        cfg_master = 1'b1;
        run_cfg(2'b10, 2'b10, 1'b1, 34, seed + 5, 1'b1);
        // R11: slave mode ignores the generator even while it toggles
        cfg_master = 1'b0;
        expect_zero = 1'b1;
        run_cfg(2'b00, 2'b11, 1'b0, 34, seed + 6, 1'b1);
        expect_zero = 1'b0;
        use_gen = 1'b0;

        summary();
        $finish;
    end

endmodule